// File: doc/BRIEF.md
# Serial Flash Write-Protection Gate

This block decides, one instruction at a time, whether a serial NOR flash device model may act on a decoded instruction. An upstream shifter presents an opcode with a valid strobe, plus the target address and the status-write data byte. In the same cycle the gate answers with exactly one of two pulses: accept or reject. It owns the write-enable latch, the protect-select bits, the status-protect bit and the lock-down flag. It also applies the start-up write hold-off and the deep sleep mode. The memory array and the real program and erase timing are outside it. The array engine reports the end of each operation with a single-cycle completion pulse.

A central state machine has four states. HOLDOFF is entered whenever power-good is low, and is left on the cycle the hold-off timer expires (HOLDOFF→READY). From READY, an accepted page program, sector erase, block erase, chip erase or status write moves to BUSY (READY→BUSY), and the completion pulse returns it (BUSY→READY). A power-down instruction moves READY→SLEEP, and only the release instruction leaves SLEEP (SLEEP→READY). Opcodes: 06h set latch, 04h clear latch, 02h page program, 20h sector erase, D8h block erase, C7h chip erase, 01h status write, 05h status read, B9h power-down, ABh release. Any other code is rejected.

Top module: `flash_wp_gate`

## Requirements
- R1: While `pwr_good_i` is low, all state is reset and `status_o` reads 00h. Every valid instruction is rejected. All lock-down, protect and latch state returns to 0 at each power-up.
- R2: During the first HOLD_CYC rising clock edges after `pwr_good_i` rises, these are rejected: 06h, 02h, 20h, D8h, C7h and 01h. Power-down (B9h) is also rejected in that window. 04h, 05h and ABh are accepted.
- R3: The write-enable latch (`status_o[1]`) is 0 after power-up. An accepted 06h sets it. 04h clears it in any state where it is accepted (HOLDOFF or READY).
- R4: 02h, 20h, D8h, C7h and 01h are rejected while the latch is 0.
- R5: An accepted 02h, 20h, D8h, C7h or 01h enters BUSY, shown by `status_o[0]`=1. In BUSY only 05h is accepted. A completion pulse in BUSY returns to READY and clears the latch. A completion pulse in any other state has no effect.
- R6: An accepted B9h enters SLEEP, shown by `sleep_o`=1. In SLEEP every instruction except ABh is rejected. ABh returns to READY.
- R7: 01h is rejected when the status-protect bit (`status_o[7]`) is 1 and `wp_n_i` is low.
- R8: An accepted 01h with data bit 6 set raises the lock flag (`status_o[6]`). The flag stays set, and every 01h is rejected, until power-good falls and rises again.
- R9: Protect code `status_o[4:2]` guards the top of a 512 KB array. Code 0 guards nothing. Codes 1 to 6 guard the top 4 KB, 8 KB, 64 KB, 128 KB, 256 KB and 512 KB. Code 7 guards everything. 02h, 20h and D8h are rejected when the last byte of their 256 B page, 4 KB sector or 64 KB block lies in the guarded region.
- R10: 0C7h is rejected whenever the protect code is nonzero.
- R11: `cmd_acc_o` and `cmd_rej_o` respond combinationally in the strobe cycle, exactly one of them high per valid instruction. A rejected instruction changes no latch, protect or lock state.
- R12: An accepted 01h loads the protect code from data bits 4:2, the status-protect bit from bit 7 and the lock flag from bit 6. The new values are visible on `status_o` from the next cycle. `status_o[5]` reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| pwr_good_i | input | 1 | Supply above threshold; low acts as asynchronous reset |
| wp_n_i | input | 1 | Write-protect pin, active low |
| cmd_valid_i | input | 1 | Instruction strobe |
| cmd_op_i | input | 8 | Instruction opcode |
| cmd_addr_i | input | ADDR_W | Target byte address |
| cmd_wdata_i | input | 8 | Data byte for the status write |
| op_done_i | input | 1 | Completion pulse from the array engine |
| cmd_acc_o | output | 1 | Instruction accepted (same cycle) |
| cmd_rej_o | output | 1 | Instruction rejected (same cycle) |
| status_o | output | 8 | {protect, lock, 0, code[2:0], latch, busy} |
| sleep_o | output | 1 | Deep power-down active |

## Verification
The bench aims at the edge of the hold-off window. A timer that is off by one cycle either accepts a set-latch instruction one cycle early or rejects one that is already legal. It probes each protect code at the byte just below the guarded region and at the first guarded byte. It also checks an erase whose block only partly overlaps the region; a design that compared the start address instead of the unit's last byte would let that erase through. Further targets are: a completion pulse arriving outside BUSY, which a sloppy design would use to clear the latch; a lock flag that a power cycle must clear but nothing else may; and instructions sent in SLEEP, which a faulty gate would obey.

// File: rtl/flash_wp_pkg.sv
package flash_wp_pkg;

    localparam logic [7:0] OP_WREN = 8'h06;
    localparam logic [7:0] OP_WRDI = 8'h04;
    localparam logic [7:0] OP_PP   = 8'h02;
    localparam logic [7:0] OP_SE   = 8'h20;
    localparam logic [7:0] OP_BE   = 8'hD8;
    localparam logic [7:0] OP_CE   = 8'hC7;
    localparam logic [7:0] OP_WRSR = 8'h01;
    localparam logic [7:0] OP_RDSR = 8'h05;
    localparam logic [7:0] OP_PD   = 8'hB9;
    localparam logic [7:0] OP_RES  = 8'hAB;

    // status / write-data field positions
    localparam int SB_BUSY = 0;
    localparam int SB_WEL  = 1;
    localparam int SB_BP_L = 2;
    localparam int SB_BP_H = 4;
    localparam int SB_LOCK = 6;
    localparam int SB_SRP  = 7;

    typedef enum logic [1:0] {
        ST_HOLDOFF = 2'd0,
        ST_READY   = 2'd1,
        ST_BUSY    = 2'd2,
        ST_SLEEP   = 2'd3
    } wp_state_e;

endpackage

// File: rtl/wp_holdoff_timer.sv
module wp_holdoff_timer #(
    parameter int HOLD_CYC = 1000
) (
    input  logic clk,
    input  logic pwr_good_i,
    output logic expire_o
);
    localparam int CW = (HOLD_CYC < 2) ? 1 : $clog2(HOLD_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);

    logic [CW-1:0] cnt_q;
    logic          run_q;

    always_ff @(posedge clk or negedge pwr_good_i) begin
        if (!pwr_good_i) begin
            cnt_q <= '0;
            run_q <= 1'b1;
        end else if (run_q) begin
            if (cnt_q == LAST) run_q <= 1'b0;
            else               cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expire_o = run_q && (cnt_q == LAST);

    assert_single_expire_R2: assert property (@(posedge clk) disable iff (!pwr_good_i)
        expire_o |=> !expire_o);

endmodule

// File: rtl/wp_region_check.sv
module wp_region_check #(
    parameter int ADDR_W    = 19,
    parameter int SECTOR_LG = 12,
    parameter int BLOCK_LG  = 16
) (
    input  logic [2:0]        bp_i,
    input  logic [ADDR_W-1:0] last_i,
    output logic              prot_o
);
    logic [7:0] hit;

    assign hit[0] = 1'b0;

    for (genvar c = 1; c < 8; c++) begin : g_code
        localparam int LG  = (c == 1) ? SECTOR_LG :
                             (c == 2) ? SECTOR_LG + 1 :
                             (c == 7) ? ADDR_W : BLOCK_LG + c - 3;
        localparam int LGC = (LG > ADDR_W) ? ADDR_W : LG;
        localparam logic [ADDR_W:0] ONE  = 1;
        localparam logic [ADDR_W:0] LOWM = (ONE << LGC) - ONE;
        // inside the top 2^LGC bytes when every bit above LGC is set
        assign hit[c] = &(last_i | LOWM[ADDR_W-1:0]);
    end

    assign prot_o = hit[bp_i];

    always_comb begin
        assert_code0_open_R9: assert (bp_i != 3'd0 || !prot_o);
        assert_code7_all_R9:  assert (bp_i != 3'd7 || prot_o);
    end

endmodule

// File: rtl/wp_ctrl_fsm.sv
module wp_ctrl_fsm
    import flash_wp_pkg::*;
(
    input  logic       clk,
    input  logic       pwr_good_i,
    input  logic       wp_n_i,
    input  logic       cmd_valid_i,
    input  logic [7:0] cmd_op_i,
    input  logic [7:0] cmd_wdata_i,
    input  logic       op_done_i,
    input  logic       hold_expire_i,
    input  logic       addr_prot_i,
    output logic [2:0] bp_o,
    output logic       cmd_acc_o,
    output logic       cmd_rej_o,
    output logic [7:0] status_o,
    output logic       sleep_o
);
    wp_state_e  state_q, state_nx;
    logic       wel_q, wel_nx;
    logic [2:0] bp_q, bp_nx;
    logic       srp_q, srp_nx;
    logic       lock_q, lock_nx;
    logic       ok;

    logic unused_wdata;
    assign unused_wdata = ^{cmd_wdata_i[5], cmd_wdata_i[1:0]};

    // next-state and acceptance decision
    always_comb begin
        ok       = 1'b0;
        state_nx = state_q;
        wel_nx   = wel_q;
        bp_nx    = bp_q;
        srp_nx   = srp_q;
        lock_nx  = lock_q;
        unique case (state_q)
            ST_HOLDOFF: begin
                if (hold_expire_i) state_nx = ST_READY;
                if (cmd_valid_i) begin
                    case (cmd_op_i)
                        OP_WRDI: begin ok = 1'b1; wel_nx = 1'b0; end
                        OP_RDSR,
                        OP_RES:  ok = 1'b1;
                        default: ok = 1'b0;
                    endcase
                end
            end
            ST_READY: begin
                if (cmd_valid_i) begin
                    case (cmd_op_i)
                        OP_WREN: begin ok = 1'b1; wel_nx = 1'b1; end
                        OP_WRDI: begin ok = 1'b1; wel_nx = 1'b0; end
                        OP_RDSR,
                        OP_RES:  ok = 1'b1;
                        OP_PD:   begin ok = 1'b1; state_nx = ST_SLEEP; end
                        OP_PP,
                        OP_SE,
                        OP_BE: begin
                            if (wel_q && !addr_prot_i) begin
                                ok = 1'b1; state_nx = ST_BUSY;
                            end
                        end
                        OP_CE: begin
                            if (wel_q && (bp_q == 3'd0)) begin
                                ok = 1'b1; state_nx = ST_BUSY;
                            end
                        end
                        OP_WRSR: begin
                            if (wel_q && !lock_q && !(srp_q && !wp_n_i)) begin
                                ok       = 1'b1;
                                state_nx = ST_BUSY;
                                bp_nx    = cmd_wdata_i[SB_BP_H:SB_BP_L];
                                srp_nx   = cmd_wdata_i[SB_SRP];
                                lock_nx  = cmd_wdata_i[SB_LOCK];
                            end
                        end
                        default: ok = 1'b0;
                    endcase
                end
            end
            ST_BUSY: begin
                if (op_done_i) begin
                    state_nx = ST_READY;
                    wel_nx   = 1'b0;
                end
                ok = cmd_valid_i && (cmd_op_i == OP_RDSR);
            end
            ST_SLEEP: begin
                if (cmd_valid_i && (cmd_op_i == OP_RES)) begin
                    ok       = 1'b1;
                    state_nx = ST_READY;
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge pwr_good_i) begin
        if (!pwr_good_i) begin
            state_q <= ST_HOLDOFF;
            wel_q   <= 1'b0;
            bp_q    <= 3'd0;
            srp_q   <= 1'b0;
            lock_q  <= 1'b0;
        end else begin
            state_q <= state_nx;
            wel_q   <= wel_nx;
            bp_q    <= bp_nx;
            srp_q   <= srp_nx;
            lock_q  <= lock_nx;
        end
    end

    // outputs
    always_comb begin
        cmd_acc_o = pwr_good_i && cmd_valid_i && ok;
        cmd_rej_o = cmd_valid_i && !cmd_acc_o;
        status_o  = {srp_q, lock_q, 1'b0, bp_q, wel_q, (state_q == ST_BUSY)};
        sleep_o   = (state_q == ST_SLEEP);
        bp_o      = bp_q;
    end

    assert_latch_clear_in_holdoff_R3: assert property (@(posedge clk) disable iff (!pwr_good_i)
        (state_q == ST_HOLDOFF) |-> !wel_q);

    assert_done_clears_latch_R5: assert property (@(posedge clk) disable iff (!pwr_good_i)
        (state_q == ST_BUSY && op_done_i) |=> (!wel_q && state_q == ST_READY));

    assert_busy_only_status_R5: assert property (@(posedge clk) disable iff (!pwr_good_i)
        (state_q == ST_BUSY && cmd_acc_o) |-> (cmd_op_i == OP_RDSR));

    assert_sleep_only_release_R6: assert property (@(posedge clk) disable iff (!pwr_good_i)
        (state_q == ST_SLEEP && cmd_acc_o) |-> (cmd_op_i == OP_RES));

    assert_pin_blocks_wrsr_R7: assert property (@(posedge clk) disable iff (!pwr_good_i)
        (cmd_valid_i && cmd_op_i == OP_WRSR && srp_q && !wp_n_i) |-> !cmd_acc_o);

    assert_lock_sticky_R8: assert property (@(posedge clk) disable iff (!pwr_good_i)
        lock_q |=> lock_q);

    assert_ce_open_only_R10: assert property (@(posedge clk) disable iff (!pwr_good_i)
        (cmd_acc_o && cmd_op_i == OP_CE) |-> (bp_q == 3'd0));

    assert_one_response_R11: assert property (@(posedge clk) disable iff (!pwr_good_i)
        cmd_valid_i |-> (cmd_acc_o != cmd_rej_o));

    assert_reject_no_change_R11: assert property (@(posedge clk) disable iff (!pwr_good_i)
        (cmd_rej_o && !(state_q == ST_BUSY && op_done_i))
        |=> (wel_q == $past(wel_q) && bp_q == $past(bp_q) && lock_q == $past(lock_q)));

endmodule

// File: rtl/flash_wp_gate.sv
module flash_wp_gate
    import flash_wp_pkg::*;
#(
    parameter int ADDR_W    = 19,
    parameter int HOLD_CYC  = 1000,
    parameter int PAGE_LG   = 8,
    parameter int SECTOR_LG = 12,
    parameter int BLOCK_LG  = 16
) (
    input  logic              clk,
    input  logic              pwr_good_i,
    input  logic              wp_n_i,
    input  logic              cmd_valid_i,
    input  logic [7:0]        cmd_op_i,
    input  logic [ADDR_W-1:0] cmd_addr_i,
    input  logic [7:0]        cmd_wdata_i,
    input  logic              op_done_i,
    output logic              cmd_acc_o,
    output logic              cmd_rej_o,
    output logic [7:0]        status_o,
    output logic              sleep_o
);
    localparam logic [ADDR_W-1:0] PAGE_M   = ADDR_W'((1 << PAGE_LG) - 1);
    localparam logic [ADDR_W-1:0] SECTOR_M = ADDR_W'((1 << SECTOR_LG) - 1);
    localparam logic [ADDR_W-1:0] BLOCK_M  = ADDR_W'((1 << BLOCK_LG) - 1);

    logic              hold_expire;
    logic              addr_prot;
    logic [2:0]        bp;
    logic [ADDR_W-1:0] last_addr;

    // last byte touched by the instruction's unit
    always_comb begin
        case (cmd_op_i)
            OP_PP:   last_addr = cmd_addr_i | PAGE_M;
            OP_SE:   last_addr = cmd_addr_i | SECTOR_M;
            OP_BE:   last_addr = cmd_addr_i | BLOCK_M;
            default: last_addr = cmd_addr_i;
        endcase
    end

    wp_holdoff_timer #(.HOLD_CYC(HOLD_CYC)) u_timer (
        .clk        (clk),
        .pwr_good_i (pwr_good_i),
        .expire_o   (hold_expire)
    );

    wp_region_check #(
        .ADDR_W    (ADDR_W),
        .SECTOR_LG (SECTOR_LG),
        .BLOCK_LG  (BLOCK_LG)
    ) u_region (
        .bp_i   (bp),
        .last_i (last_addr),
        .prot_o (addr_prot)
    );

    wp_ctrl_fsm u_fsm (
        .clk           (clk),
        .pwr_good_i    (pwr_good_i),
        .wp_n_i        (wp_n_i),
        .cmd_valid_i   (cmd_valid_i),
        .cmd_op_i      (cmd_op_i),
        .cmd_wdata_i   (cmd_wdata_i),
        .op_done_i     (op_done_i),
        .hold_expire_i (hold_expire),
        .addr_prot_i   (addr_prot),
        .bp_o          (bp),
        .cmd_acc_o     (cmd_acc_o),
        .cmd_rej_o     (cmd_rej_o),
        .status_o      (status_o),
        .sleep_o       (sleep_o)
    );

endmodule

// File: tb/sim_flash_wp_gate.sv
module sim_flash_wp_gate;

    localparam int AW    = 19;
    localparam int HOLD  = 8;
    localparam int ARRAY = 1 << AW;
    localparam int M_READY = 0, M_BUSY = 1, M_SLEEP = 2;

    logic          clk = 1'b1;
    logic          pg = 1'b1;
    logic          pg_want = 1'b0;
    logic          wpn = 1'b1;
    logic          v = 1'b0;
    logic [7:0]    op = 8'h00;
    logic [AW-1:0] addr = '0;
    logic [7:0]    wd = 8'h00;
    logic          dn = 1'b0;
    logic          acc, rej, slp;
    logic [7:0]    st;

    int n_chk = 0;
    int n_bad = 0;

    // behavioural reference state
    int m_edges, m_mode, m_wel, m_bp, m_srp, m_lock;

    always #5 clk = ~clk;

    flash_wp_gate #(.ADDR_W(AW), .HOLD_CYC(HOLD)) u0 (
        .clk(clk), .pwr_good_i(pg), .wp_n_i(wpn), .cmd_valid_i(v),
        .cmd_op_i(op), .cmd_addr_i(addr), .cmd_wdata_i(wd), .op_done_i(dn),
        .cmd_acc_o(acc), .cmd_rej_o(rej), .status_o(st), .sleep_o(slp)
    );

    task automatic model_reset();
        m_edges = 0; m_mode = M_READY; m_wel = 0; m_bp = 0; m_srp = 0; m_lock = 0;
    endtask

    function automatic int region_bytes(int code);
        case (code)
            0: return 0;
            1: return 4096;
            2: return 8192;
            3: return 65536;
            4: return 131072;
            5: return 262144;
            6: return 524288;
            default: return ARRAY;
        endcase
    endfunction

    function automatic bit guarded(logic [7:0] o, int a);
        int span = (o == 8'h02) ? 256 : (o == 8'h20) ? 4096 : 65536;
        int last = (a / span) * span + span - 1;
        int sz = region_bytes(m_bp);
        return (sz != 0) && (last >= ARRAY - sz);
    endfunction

    function automatic bit m_accept();
        if (!pg || !v) return 0;
        if (m_edges < HOLD) return (op == 8'h04 || op == 8'h05 || op == 8'hAB);
        if (m_mode == M_BUSY)  return op == 8'h05;
        if (m_mode == M_SLEEP) return op == 8'hAB;
        case (op)
            8'h06, 8'h04, 8'h05, 8'hAB, 8'hB9: return 1;
            8'h02, 8'h20, 8'hD8: return m_wel == 1 && !guarded(op, int'(addr));
            8'hC7: return m_wel == 1 && m_bp == 0;
            8'h01: return m_wel == 1 && m_lock == 0 && !(m_srp == 1 && !wpn);
            default: return 0;
        endcase
    endfunction

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic step(string tag, logic sv, logic [7:0] so, int sa, logic [7:0] sd, logic sdn);
        bit e;
        logic [7:0] es;
        @(negedge clk);
        if (pg && !pg_want) model_reset();
        pg = pg_want;
        v = sv; op = so; addr = AW'(sa); wd = sd; dn = sdn;
        #1;
        e  = m_accept();
        es = {1'(m_srp), 1'(m_lock), 1'b0, 3'(m_bp), 1'(m_wel), (m_mode == M_BUSY)};
        check(tag, "acc", 32'(acc), 32'(e));
        check(tag, "rej", 32'(rej), 32'(sv && !e));
        check(tag, "status", 32'(st), 32'(es));
        check(tag, "sleep", 32'(slp), 32'(m_mode == M_SLEEP));
        @(posedge clk);
        if (!pg) model_reset();
        else begin
            if (m_mode == M_BUSY && sdn) begin m_mode = M_READY; m_wel = 0; end
            if (e) begin
                case (so)
                    8'h06: m_wel = 1;
                    8'h04: m_wel = 0;
                    8'hB9: m_mode = M_SLEEP;
                    8'hAB: if (m_mode == M_SLEEP) m_mode = M_READY;
                    8'h02, 8'h20, 8'hD8, 8'hC7: m_mode = M_BUSY;
                    8'h01: begin
                        m_mode = M_BUSY; m_bp = int'(sd[4:2]);
                        m_srp = int'(sd[7]); m_lock = int'(sd[6]);
                    end
                    default: ;
                endcase
            end
            if (m_edges < HOLD) m_edges++;
        end
    endtask

    task automatic power_up(string tag);
        pg_want = 1'b0;
        for (int i = 0; i < 3; i++) step(tag, 1, 8'h06, 0, 8'h00, 0);
        pg_want = 1'b1;
        for (int i = 0; i < HOLD + 1; i++) step("R2", 1, (i % 2 == 0) ? 8'h06 : 8'h05, 0, 8'h00, 0);
    endtask

    task automatic wr_op(string tag, logic [7:0] o, int a, logic [7:0] d);
        step(tag, 1, 8'h06, 0, 8'h00, 0);
        step(tag, 1, o, a, d, 0);
        step(tag, 0, 8'h00, 0, 8'h00, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++; n_chk++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] ops [12] = '{8'h06, 8'h04, 8'h02, 8'h20, 8'hD8, 8'hC7,
                                 8'h01, 8'h05, 8'hB9, 8'hAB, 8'hFF, 8'h06};
        model_reset();
        // R1 reset and low power-good
        pg_want = 1'b0;
        for (int i = 0; i < 3; i++) step("R1", 1, 8'h05, 0, 8'h00, 0);
        pg_want = 1'b1;
        // R2 hold-off window, edge by edge
        step("R2", 1, 8'h06, 0, 8'h00, 0);
        step("R2", 1, 8'hB9, 0, 8'h00, 0);
        step("R3", 1, 8'h04, 0, 8'h00, 0);
        step("R2", 1, 8'h02, 0, 8'h00, 0);
        step("R2", 1, 8'hAB, 0, 8'h00, 0);
        step("R2", 1, 8'h05, 0, 8'h00, 0);
        step("R2", 1, 8'h01, 0, 8'h00, 0);
        step("R2", 1, 8'h06, 0, 8'h00, 0);
        step("R2", 1, 8'h06, 0, 8'h00, 0);
        step("R4", 1, 8'h04, 0, 8'h00, 0);
        // R4 latch required
        step("R4", 1, 8'h02, 0, 8'h00, 0);
        step("R4", 1, 8'h01, 0, 8'h1C, 0);
        step("R4", 1, 8'hC7, 0, 8'h00, 0);
        // R3 set/clear, R5 busy handling
        step("R3", 1, 8'h06, 0, 8'h00, 0);
        step("R3", 1, 8'h04, 0, 8'h00, 0);
        step("R5", 0, 8'h00, 0, 8'h00, 1);
        step("R3", 1, 8'h06, 0, 8'h00, 0);
        step("R5", 1, 8'h02, 0, 8'h00, 0);
        step("R5", 1, 8'h06, 0, 8'h00, 0);
        step("R5", 1, 8'h04, 0, 8'h00, 0);
        step("R5", 1, 8'hB9, 0, 8'h00, 0);
        step("R5", 1, 8'h05, 0, 8'h00, 1);
        step("R5", 0, 8'h00, 0, 8'h00, 1);
        // R12 status write, R9 partial overlap, R10 chip erase
        wr_op("R12", 8'h01, 0, 8'h24);
        wr_op("R9", 8'h02, 32'h7FF00, 8'h00);
        wr_op("R9", 8'h02, 32'h7EFFF, 8'h00);
        wr_op("R9", 8'h20, 32'h7F123, 8'h00);
        wr_op("R9", 8'h20, 32'h7E000, 8'h00);
        wr_op("R9", 8'hD8, 32'h70000, 8'h00);
        wr_op("R9", 8'hD8, 32'h6FFFF, 8'h00);
        wr_op("R10", 8'hC7, 0, 8'h00);
        // R9 every code at both sides of its boundary
        for (int c = 0; c < 8; c++) begin
            int sz;
            wr_op("R12", 8'h01, 0, 8'(c << 2));
            sz = region_bytes(c);
            wr_op("R9", 8'h02, ARRAY - sz - 1, 8'h00);
            wr_op("R9", 8'h02, ARRAY - sz, 8'h00);
            wr_op("R9", 8'h02, ARRAY - 1, 8'h00);
        end
        wr_op("R12", 8'h01, 0, 8'h00);
        wr_op("R10", 8'hC7, 0, 8'h00);
        // R7 status-protect with pin
        wr_op("R7", 8'h01, 0, 8'h80);
        wpn = 1'b0;
        wr_op("R7", 8'h01, 0, 8'h00);
        wpn = 1'b1;
        wr_op("R7", 8'h01, 0, 8'h00);
        // R6 sleep
        step("R6", 1, 8'hB9, 0, 8'h00, 0);
        step("R6", 1, 8'h06, 0, 8'h00, 0);
        step("R6", 1, 8'h05, 0, 8'h00, 1);
        step("R6", 1, 8'h04, 0, 8'h00, 0);
        step("R6", 1, 8'hAB, 0, 8'h00, 0);
        step("R6", 1, 8'h06, 0, 8'h00, 0);
        // R11 unknown opcode keeps latch
        step("R11", 1, 8'hFF, 0, 8'h00, 0);
        step("R11", 1, 8'h03, 0, 8'h00, 0);
        step("R11", 0, 8'h00, 0, 8'h00, 0);
        // R8 lock-down until power cycle
        step("R8", 0, 8'h00, 0, 8'h00, 1);
        wr_op("R8", 8'h01, 0, 8'h48);
        wr_op("R8", 8'h01, 0, 8'h00);
        wr_op("R8", 8'h01, 0, 8'h00);
        power_up("R1");
        wr_op("R8", 8'h01, 0, 8'h04);
        // mixed traffic
        for (int i = 0; i < 600; i++) begin
            if (i % 200 == 199) power_up("R1");
            wpn = 1'($urandom_range(1));
            step("R11", 1'($urandom_range(7) != 0), ops[$urandom_range(11)],
                 int'($urandom_range(ARRAY - 1)), 8'($urandom),
                 1'($urandom_range(2) == 0));
        end
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule